// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides which low-power state the core enters when the processor stalls on a wait-for-interrupt or wait-for-event, and it drives the clock, oscillator and regulator controls for that state. Three targets exist. Sleep gates only the CPU clock. Stop gates every clock in the core domain and stops the oscillators, with the regulator kept in normal mode or dropped to low-power mode. Standby powers the core domain down. The choice comes from the deep-sleep bit together with a power-down select and a low-power-regulator select.

Stop entry is refused when any external-line, peripheral or alarm pending flag is set. It is also held off while a flash program or a peripheral bus transfer is still running. On the way out of Stop, the block pulses a request that switches the system clock to the internal RC oscillator. If the low-power regulator was in use, the block first waits a programmable number of cycles so the regulator can recover. While the block is in Stop, a peripheral clock request lifts the regulator back to normal mode. Standby is left only through a system reset, which the block requests on a wake pin or alarm rising edge, or on an external or watchdog reset request.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: When a wait request arrives in Run with deep_sleep=0, the next cycle shows Sleep: cpu_clk_en=0, dom_clk_en=1, osc_en=1 and reg_mode=2'b00 (normal). The pdds, lpds and pending inputs play no part in this choice.
- R2: When a wait request arrives with deep_sleep=1, pdds=0, no pending flag set and no busy input, the next cycle shows Stop: cpu_clk_en=0, dom_clk_en=0 and osc_en=0. reg_mode is 2'b01 (low-power) if lpds was 1 at entry, and 2'b00 otherwise.
- R3: When a wait request arrives with deep_sleep=1 and pdds=1, the next cycle shows Standby: sby_pwr_off=1, reg_mode=2'b10 (off) and all clock and oscillator enables at 0. Pending flags do not block this entry. sbf_set_pulse is 1 for exactly the first Standby cycle.
- R4: A Stop request made while pend_exti, pend_periph or pend_alarm is 1 is dropped, and cpu_clk_en stays 1. A pending flag that rises while Stop entry is being held off also returns the block to Run.
- R5: While flash_busy or apb_busy is 1, a Stop request keeps dom_clk_en=1 and osc_en=1 with cpu_clk_en=0. Stop is entered in the cycle after both busy inputs read 0.
- R6: When Stop ends, hsi_sel_pulse is 1 for the first Run cycle only. It stays 0 when Sleep ends.
- R7: In Stop with the low-power regulator, reg_mode reads 2'b00 while periph_clk_req=1 and goes back to 2'b01 once the request is removed.
- R8: Sleep entered by wait-for-interrupt (wait_is_evt=0) ends on irq_any and ignores evt_any. Sleep entered by wait-for-event ends on evt_any and ignores irq_any.
- R9: exc_return with sleep_on_exit=1 enters Sleep the same way an interrupt-type wait request does. With sleep_on_exit=0, exc_return has no effect.
- R10: In Standby, irq_any and evt_any have no effect. sby_exit_rst pulses for one cycle on a rising edge of wkup_pin or alarm_evt, and on ext_rst_req or wdg_rst_req. The block stays in Standby until rst_n is asserted.
- R11: When Stop with the low-power regulator ends and wake_dly=D is not 0, cpu_clk_en stays 0 for D cycles after the wake cycle, with reg_mode=2'b00 and osc_en=1. When D=0, or when the regulator was normal, Run follows at once.
- R12: After reset: cpu_clk_en=1, dom_clk_en=1, osc_en=1, reg_mode=2'b00, and sby_pwr_off, hsi_sel_pulse, sbf_set_pulse and sby_exit_rst all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low system reset |
| wait_req | input | 1 | One-cycle pulse: CPU executed a wait instruction |
| wait_is_evt | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| exc_return | input | 1 | Pulse on return from the last interrupt handler |
| deep_sleep | input | 1 | Deep-sleep select |
| sleep_on_exit | input | 1 | Sleep on interrupt return enable |
| pdds | input | 1 | Deep sleep powers down (Standby) when 1 |
| lpds | input | 1 | Low-power regulator during Stop when 1 |
| pend_exti | input | 1 | Any external-line pending bit |
| pend_periph | input | 1 | Any peripheral interrupt pending bit |
| pend_alarm | input | 1 | Alarm flag set |
| flash_busy | input | 1 | Flash programming in progress |
| apb_busy | input | 1 | Peripheral bus access in progress |
| irq_any | input | 1 | Wake interrupt present |
| evt_any | input | 1 | Wake event present |
| wkup_pin | input | 1 | Enabled wake pin level |
| alarm_evt | input | 1 | Alarm event level |
| ext_rst_req | input | 1 | External reset request |
| wdg_rst_req | input | 1 | Watchdog reset request |
| periph_clk_req | input | 1 | Peripheral needs a clock during Stop |
| wake_dly | input | DLY_W | Regulator recovery cycles after low-power Stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| dom_clk_en | output | 1 | Core-domain clock enable |
| osc_en | output | 1 | PLL and main oscillator enable |
| reg_mode | output | 2 | 00 normal, 01 low-power, 10 off |
| sby_pwr_off | output | 1 | Core-domain power-off command |
| hsi_sel_pulse | output | 1 | Select internal RC oscillator as system clock |
| sbf_set_pulse | output | 1 | Set the standby flag |
| sby_exit_rst | output | 1 | Reset request that ends Standby |

## Verification
The bench goes after the pending-flag and busy interplay. A design that checks pending flags only at the request would still enter Stop when a flag rises during the busy hold. A design that ignores the busy inputs would gate the domain clocks in the middle of a transfer. The bench also counts the cycles of the low-power wake delay exactly, so an off-by-one counter is caught by a clock that comes back one cycle early or late. It confirms that the wrong wake kind (an event in wait-for-interrupt Sleep, or an interrupt in Standby) leaves the clocks gated, and that a wake pin held high produces no second reset request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_HOLD  = 3'd2,
    ST_STOP  = 3'd3,
    ST_WAKE  = 3'd4,
    ST_SBY   = 3'd5
  } lpm_state_e;

  localparam logic [1:0] REG_NORMAL = 2'b00;
  localparam logic [1:0] REG_LOWPWR = 2'b01;
  localparam logic [1:0] REG_OFF    = 2'b10;

  // Target state for a wait request taken in Run.
  function automatic lpm_state_e pick_entry(input logic deep, input logic pdn,
                                            input logic pend, input logic busy);
    if (!deep)     return ST_SLEEP;
    else if (pdn)  return ST_SBY;
    else if (pend) return ST_RUN;
    else if (busy) return ST_HOLD;
    else           return ST_STOP;
  endfunction

  // Regulator setting for a given state.
  function automatic logic [1:0] reg_for(input lpm_state_e st, input logic lp_sel,
                                         input logic clk_req);
    if (st == ST_SBY)                          return REG_OFF;
    else if (st == ST_STOP && lp_sel && !clk_req) return REG_LOWPWR;
    else                                       return REG_NORMAL;
  endfunction

endpackage

// File: rtl/lpm_edge_det.sv
module lpm_edge_det #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  output logic            any_rise
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise[i] = lvl[i] & ~prev_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign any_rise = |rise;
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             done
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign done = (cnt_q == ONE);
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic             wait_is_evt,
  input  logic             exc_return,
  input  logic             deep_sleep,
  input  logic             sleep_on_exit,
  input  logic             pdds,
  input  logic             lpds,
  input  logic             pend_exti,
  input  logic             pend_periph,
  input  logic             pend_alarm,
  input  logic             flash_busy,
  input  logic             apb_busy,
  input  logic             irq_any,
  input  logic             evt_any,
  input  logic             wkup_pin,
  input  logic             alarm_evt,
  input  logic             ext_rst_req,
  input  logic             wdg_rst_req,
  input  logic             periph_clk_req,
  input  logic [DLY_W-1:0] wake_dly,
  output logic             cpu_clk_en,
  output logic             dom_clk_en,
  output logic             osc_en,
  output logic [1:0]       reg_mode,
  output logic             sby_pwr_off,
  output logic             hsi_sel_pulse,
  output logic             sbf_set_pulse,
  output logic             sby_exit_rst
);

  lpm_state_e state_q, state_n;
  logic wfe_q, lpds_q;
  logic hsi_q, sbf_q, sbyrst_q;

  // Named internal events
  logic trig, trig_evt, pend_any, busy_any, wake_hit;
  logic stop_exit, sby_entry, pin_rise, sby_src, tmr_load, tmr_done;

  assign trig      = wait_req | (exc_return & sleep_on_exit);
  assign trig_evt  = wait_req & wait_is_evt;
  assign pend_any  = pend_exti | pend_periph | pend_alarm;
  assign busy_any  = flash_busy | apb_busy;
  assign wake_hit  = wfe_q ? evt_any : irq_any;
  assign sby_src   = pin_rise | ext_rst_req | wdg_rst_req;

  lpm_edge_det #(.NSRC(2)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      ({alarm_evt, wkup_pin}),
    .any_rise (pin_rise)
  );

  lpm_wake_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (wake_dly),
    .done     (tmr_done)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN:   if (trig) state_n = pick_entry(deep_sleep, pdds, pend_any, busy_any);
      ST_SLEEP: if (wake_hit) state_n = ST_RUN;
      ST_HOLD:  if (pend_any) state_n = ST_RUN;
                else if (!busy_any) state_n = ST_STOP;
      ST_STOP:  if (wake_hit) state_n = (lpds_q && wake_dly != '0) ? ST_WAKE : ST_RUN;
      ST_WAKE:  if (tmr_done) state_n = ST_RUN;
      ST_SBY:   state_n = ST_SBY;
      default:  state_n = ST_RUN;
    endcase
  end

  assign tmr_load  = (state_q == ST_STOP) && (state_n == ST_WAKE);
  assign stop_exit = (state_q == ST_STOP || state_q == ST_WAKE) && (state_n == ST_RUN);
  assign sby_entry = (state_q != ST_SBY) && (state_n == ST_SBY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      wfe_q    <= 1'b0;
      lpds_q   <= 1'b0;
      hsi_q    <= 1'b0;
      sbf_q    <= 1'b0;
      sbyrst_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      if (state_q == ST_RUN && trig) begin
        wfe_q  <= trig_evt;
        lpds_q <= lpds;
      end
      hsi_q    <= stop_exit;
      sbf_q    <= sby_entry;
      sbyrst_q <= (state_q == ST_SBY) && sby_src;
    end
  end

  assign cpu_clk_en    = (state_q == ST_RUN);
  assign dom_clk_en    = (state_q == ST_RUN) || (state_q == ST_SLEEP) || (state_q == ST_HOLD);
  assign osc_en        = dom_clk_en || (state_q == ST_WAKE);
  assign reg_mode      = reg_for(state_q, lpds_q, periph_clk_req);
  assign sby_pwr_off   = (state_q == ST_SBY);
  assign hsi_sel_pulse = hsi_q;
  assign sbf_set_pulse = sbf_q;
  assign sby_exit_rst  = sbyrst_q;

  // Assertions
  assert_pend_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && trig && deep_sleep && !pdds && pend_any) |=> cpu_clk_en);

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && busy_any && !pend_any) |=> (dom_clk_en && !cpu_clk_en));

  assert_hsi_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hsi_sel_pulse |=> !hsi_sel_pulse);

  assert_sleep_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wfe_q && !evt_any) |=> !cpu_clk_en);

  assert_sby_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sby_pwr_off |=> sby_pwr_off);

  assert_sbf_in_sby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sbf_set_pulse |-> (sby_pwr_off && !dom_clk_en));

endmodule

// File: tb/lpm_entry_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_entry_ctrl_bench;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, wait_is_evt = 0, exc_return = 0, deep_sleep = 0, sleep_on_exit = 0;
  logic pdds = 0, lpds = 0, pend_exti = 0, pend_periph = 0, pend_alarm = 0;
  logic flash_busy = 0, apb_busy = 0, irq_any = 0, evt_any = 0;
  logic wkup_pin = 0, alarm_evt = 0, ext_rst_req = 0, wdg_rst_req = 0, periph_clk_req = 0;
  logic [DLY_W-1:0] wake_dly = '0;
  logic cpu_clk_en, dom_clk_en, osc_en, sby_pwr_off, hsi_sel_pulse, sbf_set_pulse, sby_exit_rst;
  logic [1:0] reg_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  lpm_entry_ctrl #(.DLY_W(DLY_W)) u_lpm_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wait_is_evt(wait_is_evt),
    .exc_return(exc_return), .deep_sleep(deep_sleep), .sleep_on_exit(sleep_on_exit),
    .pdds(pdds), .lpds(lpds), .pend_exti(pend_exti), .pend_periph(pend_periph),
    .pend_alarm(pend_alarm), .flash_busy(flash_busy), .apb_busy(apb_busy),
    .irq_any(irq_any), .evt_any(evt_any), .wkup_pin(wkup_pin), .alarm_evt(alarm_evt),
    .ext_rst_req(ext_rst_req), .wdg_rst_req(wdg_rst_req), .periph_clk_req(periph_clk_req),
    .wake_dly(wake_dly), .cpu_clk_en(cpu_clk_en), .dom_clk_en(dom_clk_en), .osc_en(osc_en),
    .reg_mode(reg_mode), .sby_pwr_off(sby_pwr_off), .hsi_sel_pulse(hsi_sel_pulse),
    .sbf_set_pulse(sbf_set_pulse), .sby_exit_rst(sby_exit_rst)
  );

  // Vector: [10:6] {deep,pdds,lpds,pend,evt}  [5:0] {cpu,dom,osc,reg[1:0],off}
  localparam logic [10:0] VEC [8] = '{
    {5'b00000, 6'b011000},   // Sleep, WFI
    {5'b00001, 6'b011000},   // Sleep, WFE
    {5'b01110, 6'b011000},   // Sleep ignores pdds/lpds/pending
    {5'b10000, 6'b000000},   // Stop, regulator normal
    {5'b10100, 6'b000010},   // Stop, regulator low-power
    {5'b10110, 6'b111000},   // Stop refused by pending
    {5'b11000, 6'b000101},   // Standby
    {5'b11110, 6'b000101}    // Standby despite pending
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse_wait(input logic evt);
    wait_req = 1'b1; wait_is_evt = evt;
    step();
    wait_req = 1'b0; wait_is_evt = 1'b0;
  endtask

  task automatic clear_cfg();
    deep_sleep = 0; pdds = 0; lpds = 0; pend_exti = 0; pend_periph = 0; pend_alarm = 0;
    flash_busy = 0; apb_busy = 0; sleep_on_exit = 0; periph_clk_req = 0; wake_dly = '0;
  endtask

  task automatic wake_both();
    irq_any = 1; evt_any = 1;
    step();
    irq_any = 0; evt_any = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 clocks", {5'b0, cpu_clk_en, dom_clk_en, osc_en}, 8'h07);
    chk("R12 reg", {6'b0, reg_mode}, 8'h00);
    chk("R12 pulses", {4'b0, sby_pwr_off, hsi_sel_pulse, sbf_set_pulse, sby_exit_rst}, 8'h00);

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      clear_cfg();
      {deep_sleep, pdds, lpds, pend_exti} = VEC[i][10:7];
      pulse_wait(VEC[i][6]);
      chk("R1/R2/R3/R4 entry", {2'b0, cpu_clk_en, dom_clk_en, osc_en, reg_mode, sby_pwr_off},
          {2'b0, VEC[i][5:0]});
      if (VEC[i][0]) begin
        chk("R3 sbf pulse", {7'b0, sbf_set_pulse}, 8'h01);
        step();
        chk("R3 sbf single", {7'b0, sbf_set_pulse}, 8'h00);
        clear_cfg();
        do_reset();
      end else if (!VEC[i][5]) begin
        clear_cfg();
        wake_both();
      end
      chk("R8/R12 back to run", {7'b0, cpu_clk_en}, 8'h01);
      step();
    end

    // R4 other pending sources
    clear_cfg(); deep_sleep = 1; pend_periph = 1;
    pulse_wait(0);
    chk("R4 periph pending", {7'b0, cpu_clk_en}, 8'h01);
    pend_periph = 0; pend_alarm = 1;
    pulse_wait(0);
    chk("R4 alarm pending", {7'b0, cpu_clk_en}, 8'h01);

    // R5 busy hold-off
    clear_cfg(); deep_sleep = 1; flash_busy = 1;
    pulse_wait(0);
    for (int k = 0; k < 3; k++) begin
      chk("R5 flash hold", {5'b0, cpu_clk_en, dom_clk_en, osc_en}, 8'h03);
      if (k == 1) begin flash_busy = 0; apb_busy = 1; end
      step();
    end
    apb_busy = 0;
    step();
    chk("R5 stop after idle", {6'b0, dom_clk_en, osc_en}, 8'h00);
    wake_both();
    // R6 stop exit HSI pulse
    chk("R6 hsi pulse", {6'b0, cpu_clk_en, hsi_sel_pulse}, 8'h03);
    step();
    chk("R6 hsi single", {7'b0, hsi_sel_pulse}, 8'h00);

    // R4 pending arriving during hold aborts
    clear_cfg(); deep_sleep = 1; apb_busy = 1;
    pulse_wait(0);
    pend_exti = 1;
    step();
    chk("R4 pending in hold", {7'b0, cpu_clk_en}, 8'h01);
    clear_cfg(); step();

    // R7 peripheral clock request in low-power Stop
    deep_sleep = 1; lpds = 1;
    pulse_wait(0);
    chk("R7 lp reg", {6'b0, reg_mode}, 8'h01);
    periph_clk_req = 1; #1;
    chk("R7 req raises reg", {6'b0, reg_mode}, 8'h00);
    step(); periph_clk_req = 0; #1;
    chk("R7 req removed", {6'b0, reg_mode}, 8'h01);

    // R11 wake delay of 5 cycles
    wake_dly = 8'd5;
    wake_both();
    for (int k = 1; k <= 4; k++) step();
    chk("R11 still waiting cycle 5", {5'b0, cpu_clk_en, osc_en, reg_mode[0]}, 8'h02);
    step();
    chk("R11 run after delay", {6'b0, cpu_clk_en, hsi_sel_pulse}, 8'h03);
    clear_cfg(); step();

    // R6 no HSI pulse on Sleep exit; R8 wake kinds
    pulse_wait(0);
    evt_any = 1; step(); evt_any = 0;
    chk("R8 WFI sleep ignores event", {7'b0, cpu_clk_en}, 8'h00);
    irq_any = 1; step(); irq_any = 0;
    chk("R8/R6 WFI sleep wakes no hsi", {6'b0, cpu_clk_en, hsi_sel_pulse}, 8'h02);
    pulse_wait(1);
    irq_any = 1; step(); irq_any = 0;
    chk("R8 WFE sleep ignores irq", {7'b0, cpu_clk_en}, 8'h00);
    evt_any = 1; step(); evt_any = 0;
    chk("R8 WFE sleep wakes", {7'b0, cpu_clk_en}, 8'h01);

    // R9 sleep-on-exit
    exc_return = 1; step(); exc_return = 0;
    chk("R9 no soe", {7'b0, cpu_clk_en}, 8'h01);
    sleep_on_exit = 1; exc_return = 1; step(); exc_return = 0;
    chk("R9 soe sleep", {6'b0, cpu_clk_en, dom_clk_en}, 8'h01);
    irq_any = 1; step(); irq_any = 0;
    chk("R9 soe wake", {7'b0, cpu_clk_en}, 8'h01);
    clear_cfg(); step();

    // R10 standby exit sources
    deep_sleep = 1; pdds = 1;
    pulse_wait(0);
    irq_any = 1; evt_any = 1; step(); irq_any = 0; evt_any = 0;
    chk("R10 irq ignored", {6'b0, sby_pwr_off, sby_exit_rst}, 8'h02);
    wkup_pin = 1; step();
    chk("R10 pin rise", {7'b0, sby_exit_rst}, 8'h01);
    step();
    chk("R10 pin held", {6'b0, sby_pwr_off, sby_exit_rst}, 8'h02);
    wkup_pin = 0; alarm_evt = 1; step(); alarm_evt = 0;
    chk("R10 alarm rise", {7'b0, sby_exit_rst}, 8'h01);
    wdg_rst_req = 1; step(); wdg_rst_req = 0;
    chk("R10 watchdog", {7'b0, sby_exit_rst}, 8'h01);
    ext_rst_req = 1; step(); ext_rst_req = 0;
    chk("R10 ext reset", {6'b0, sby_pwr_off, sby_exit_rst}, 8'h03);
    clear_cfg();
    do_reset();
    chk("R10/R12 reset exits", {6'b0, sby_pwr_off, cpu_clk_en}, 8'h01);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule